// File: doc/BRIEF.md
# Scaled-Modulus Modular Reducer

This block computes the remainder of a wide value, typically a double-length product, modulo an n-digit modulus `m`. It does not estimate quotient digits with a reciprocal. Instead it works against a precomputed multiple `m·S` of the modulus, where `S` is chosen so that the leading digits of `m·S` have a fixed pattern. With that pattern, each quotient digit is read straight off the top of the running remainder. No multiplication is spent on the estimate.

Reduction runs one digit position at a time, from the most significant position down. At each position the block forms the estimate and subtracts `q·(m·S)` digit by digit with one narrow multiplier. It then corrects the remainder one step at a time: it adds `m·S` back while the remainder is negative, and subtracts it while the remainder is still too large. When the last position is done, the remainder is below `m·S`. A closing phase then divides by the plain modulus `m`. It finds a quotient digit bit by bit with compare-and-subtract, and a final guard subtracts `m` until the result is below `m`.

Two scaling patterns are supported and are chosen per operation. With pattern 0, the scaled modulus starts with an all-ones digit, and `m` must have its top bit set. With pattern 1, the scaled modulus starts with the digits 1 then 0. The caller computes `m·S` and supplies it with `m`. Operands are latched when a start is accepted. The result stays on the output until the next accepted start.

Top module: `scaled_mod_reducer`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: With `formSel` = 0 and digit n of `scaledIn` (bits [(n+1)·16-1 : n·16]) equal to 16'hFFFF, the `result` presented with `done` equals `valueIn` mod `modIn`.
- R3: With `formSel` = 1, digit n of `scaledIn` equal to 1 and digit n-1 equal to 0, the `result` presented with `done` equals `valueIn` mod `modIn`.
- R4: Whenever `done` is 1, `result` is below the modulus latched at the accepted start.
- R5: Each accepted start produces exactly one `done`, and `done` is high for exactly one cycle.
- R6: A `start` that arrives while an operation is in progress is ignored. That operation finishes with the operands it latched, and the ignored start produces no `done` of its own.
- R7: After `done`, `result` holds its value until the next accepted start.
- R8: A value below the modulus is returned unchanged. An exact multiple of the modulus, including zero, gives 0.
- R9: An all-ones value is reduced correctly, both with the largest modulus and with the smallest modulus that has its top bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation when the block is idle |
| formSel | input | 1 | Scaling pattern: 0 = leading all-ones digit, 1 = leading digits 1 then 0 |
| valueIn | input | 2·N_DIGITS·DIGIT_W | Value to reduce |
| modIn | input | N_DIGITS·DIGIT_W | Modulus m |
| scaledIn | input | (N_DIGITS+1)·DIGIT_W | Scaled modulus m·S |
| result | output | N_DIGITS·DIGIT_W | Remainder; valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench drives random moduli under both scaling patterns and searches for a valid `S` for each one. Under pattern 0 the estimate tends to overshoot, which exercises the add-back path. Under pattern 1 the estimate tends to undershoot, which exercises the extra-subtract path. The directed cases cover values below the modulus and exact multiples of it, which check that the final compare-and-subtract does not remove too much or too little. The all-ones value is run against the largest and the smallest normalized modulus, which puts the quotient digits and the final quotient at their bounds. A start raised in the middle of a run checks that the operands latched at acceptance are the ones used.

// File: rtl/modred_pkg.sv
package modred_pkg;

  typedef enum logic {
    FORM_TOP_ONES = 1'b0,
    FORM_ONE_ZERO = 1'b1
  } scaleForm_e;

  typedef struct packed {
    logic load;
    logic estQ;
    logic mulSub;
    logic addBack;
    logic subScaled;
    logic subModShift;
    logic subMod;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EST,
    ST_MUL,
    ST_FIXNEG,
    ST_FIXPOS,
    ST_FINBIT,
    ST_GUARD,
    ST_DONE
  } ctrlState_e;

endpackage

// File: rtl/modred_dp.sv
module modred_dp #(
  parameter int N_DIGITS = 4,
  parameter int DIGIT_W  = 16,
  parameter int CNT_W    = $clog2(N_DIGITS + 1),
  parameter int BIT_W    = $clog2(DIGIT_W + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  modred_pkg::dpCtrl_t                 strb,
  input  logic [CNT_W-1:0]                    kIdx,
  input  logic [CNT_W-1:0]                    jIdx,
  input  logic [BIT_W-1:0]                    bIdx,
  input  logic                                formSel,
  input  logic [2*N_DIGITS*DIGIT_W-1:0]       valueIn,
  input  logic [N_DIGITS*DIGIT_W-1:0]         modIn,
  input  logic [(N_DIGITS+1)*DIGIT_W-1:0]     scaledIn,
  output logic                                rNeg,
  output logic                                rGeScaled,
  output logic                                rGeModShift,
  output logic                                rGeMod,
  output logic [N_DIGITS*DIGIT_W-1:0]         result
);
  import modred_pkg::*;

  localparam int VAL_W  = 2 * N_DIGITS * DIGIT_W;
  localparam int MOD_W  = N_DIGITS * DIGIT_W;
  localparam int SC_W   = (N_DIGITS + 1) * DIGIT_W;
  // Remainder: 2n+2 digits of magnitude plus sign and one guard bit.
  localparam int R_W    = (2 * N_DIGITS + 2) * DIGIT_W + 2;
  localparam int Q_W    = DIGIT_W + 1;
  localparam int PP_W   = 2 * DIGIT_W + 1;

  logic [R_W-1:0]     rReg;
  logic [MOD_W-1:0]   mReg;
  logic [SC_W-1:0]    msReg;
  scaleForm_e         formReg;
  logic [Q_W-1:0]     qReg;

  // Digits of the scaled modulus, selected by the inner-loop index.
  logic [DIGIT_W-1:0] msDigits [N_DIGITS+1];
  for (genvar g = 0; g <= N_DIGITS; g++) begin : gScaledDigit
    assign msDigits[g] = msReg[g*DIGIT_W +: DIGIT_W];
  end

  // Quotient estimate straight from the top of the remainder window.
  logic [31:0]      estShift;
  logic [R_W-1:0]   rWindow;
  logic [Q_W-1:0]   qEstimate;

  always_comb begin
    if (formReg == FORM_TOP_ONES)
      estShift = (32'(kIdx) + 32'(N_DIGITS + 1)) * DIGIT_W;
    else
      estShift = (32'(kIdx) + 32'(N_DIGITS)) * DIGIT_W;
    rWindow = rReg >> estShift;
    if (formReg == FORM_TOP_ONES)
      qEstimate = {1'b0, rWindow[DIGIT_W-1:0]} + Q_W'(1);
    else
      qEstimate = rWindow[Q_W-1:0];
  end

  // One partial product per cycle: q times one digit of m*S.
  logic [DIGIT_W-1:0] msDigit;
  logic [PP_W-1:0]    partial;
  logic [R_W-1:0]     mulTerm;
  logic [R_W-1:0]     scaledTerm;
  logic [R_W-1:0]     modShiftTerm;
  logic [R_W-1:0]     modTerm;

  assign msDigit      = msDigits[jIdx];
  assign partial      = PP_W'(qReg) * PP_W'(msDigit);
  assign mulTerm      = R_W'(partial) << ((32'(kIdx) + 32'(jIdx)) * DIGIT_W);
  assign scaledTerm   = R_W'(msReg) << (32'(kIdx) * DIGIT_W);
  assign modShiftTerm = R_W'(mReg) << bIdx;
  assign modTerm      = R_W'(mReg);

  assign rNeg        = rReg[R_W-1];
  assign rGeScaled   = !rNeg && (rReg >= scaledTerm);
  assign rGeModShift = !rNeg && (rReg >= modShiftTerm);
  assign rGeMod      = !rNeg && (rReg >= modTerm);
  assign result      = rReg[MOD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rReg    <= '0;
      mReg    <= '0;
      msReg   <= '0;
      formReg <= FORM_TOP_ONES;
      qReg    <= '0;
    end else begin
      if (strb.load) begin
        rReg    <= R_W'(valueIn);
        mReg    <= modIn;
        msReg   <= scaledIn;
        formReg <= scaleForm_e'(formSel);
      end else if (strb.estQ) begin
        qReg <= qEstimate;
      end else if (strb.mulSub) begin
        rReg <= rReg - mulTerm;
      end else if (strb.addBack) begin
        rReg <= rReg + scaledTerm;
      end else if (strb.subScaled) begin
        rReg <= rReg - scaledTerm;
      end else if (strb.subModShift) begin
        rReg <= rReg - modShiftTerm;
      end else if (strb.subMod) begin
        rReg <= rReg - modTerm;
      end
    end
  end

  localparam int UNUSED_VAL_W = VAL_W;

endmodule

// File: rtl/modred_ctrl.sv
module modred_ctrl #(
  parameter int N_DIGITS = 4,
  parameter int DIGIT_W  = 16,
  parameter int CNT_W    = $clog2(N_DIGITS + 1),
  parameter int BIT_W    = $clog2(DIGIT_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 rNeg,
  input  logic                 rGeScaled,
  input  logic                 rGeModShift,
  input  logic                 rGeMod,
  output modred_pkg::dpCtrl_t  strb,
  output logic [CNT_W-1:0]     kIdx,
  output logic [CNT_W-1:0]     jIdx,
  output logic [BIT_W-1:0]     bIdx,
  output logic                 busy,
  output logic                 done
);
  import modred_pkg::*;

  localparam logic [CNT_W-1:0] TOP_K  = CNT_W'(N_DIGITS);
  localparam logic [CNT_W-1:0] LAST_J = CNT_W'(N_DIGITS);
  localparam logic [BIT_W-1:0] TOP_B  = BIT_W'(DIGIT_W);

  ctrlState_e state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_EST;
        end
      end
      ST_EST: begin
        strb.estQ = 1'b1;
        nextState = ST_MUL;
      end
      ST_MUL: begin
        strb.mulSub = 1'b1;
        if (jIdx == LAST_J) nextState = ST_FIXNEG;
      end
      ST_FIXNEG: begin
        if (rNeg) strb.addBack = 1'b1;
        else      nextState = ST_FIXPOS;
      end
      ST_FIXPOS: begin
        if (rGeScaled)          strb.subScaled = 1'b1;
        else if (kIdx == '0)    nextState = ST_FINBIT;
        else                    nextState = ST_EST;
      end
      ST_FINBIT: begin
        if (rGeModShift) strb.subModShift = 1'b1;
        if (bIdx == '0)  nextState = ST_GUARD;
      end
      ST_GUARD: begin
        if (rGeMod) strb.subMod = 1'b1;
        else        nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kIdx  <= '0;
      jIdx  <= '0;
      bIdx  <= '0;
    end else begin
      state <= nextState;
      case (state)
        ST_IDLE:   if (start) kIdx <= TOP_K;
        ST_EST:    jIdx <= '0;
        ST_MUL:    if (jIdx != LAST_J) jIdx <= jIdx + CNT_W'(1);
        ST_FIXPOS: begin
          if (!rGeScaled) begin
            if (kIdx != '0) kIdx <= kIdx - CNT_W'(1);
            else            bIdx <= TOP_B;
          end
        end
        ST_FINBIT: if (bIdx != '0) bIdx <= bIdx - BIT_W'(1);
        default: ;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/scaled_mod_reducer.sv
module scaled_mod_reducer #(
  parameter int N_DIGITS = 4,
  parameter int DIGIT_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic                                formSel,
  input  logic [2*N_DIGITS*DIGIT_W-1:0]       valueIn,
  input  logic [N_DIGITS*DIGIT_W-1:0]         modIn,
  input  logic [(N_DIGITS+1)*DIGIT_W-1:0]     scaledIn,
  output logic [N_DIGITS*DIGIT_W-1:0]         result,
  output logic                                done
);
  localparam int CNT_W = $clog2(N_DIGITS + 1);
  localparam int BIT_W = $clog2(DIGIT_W + 1);

  modred_pkg::dpCtrl_t strb;
  logic [CNT_W-1:0]    kIdx;
  logic [CNT_W-1:0]    jIdx;
  logic [BIT_W-1:0]    bIdx;
  logic                rNeg;
  logic                rGeScaled;
  logic                rGeModShift;
  logic                rGeMod;
  logic                busy;

  modred_ctrl #(
    .N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rNeg(rNeg), .rGeScaled(rGeScaled), .rGeModShift(rGeModShift), .rGeMod(rGeMod),
    .strb(strb), .kIdx(kIdx), .jIdx(jIdx), .bIdx(bIdx),
    .busy(busy), .done(done)
  );

  modred_dp #(
    .N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .kIdx(kIdx), .jIdx(jIdx), .bIdx(bIdx),
    .formSel(formSel), .valueIn(valueIn), .modIn(modIn), .scaledIn(scaledIn),
    .rNeg(rNeg), .rGeScaled(rGeScaled), .rGeModShift(rGeModShift), .rGeMod(rGeMod),
    .result(result)
  );

endmodule

// File: rtl/modred_chk.sv
module modred_chk #(
  parameter int N_DIGITS = 4,
  parameter int DIGIT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [N_DIGITS*DIGIT_W-1:0]  modIn,
  input logic [N_DIGITS*DIGIT_W-1:0]  result
);
  logic [N_DIGITS*DIGIT_W-1:0] modCap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              modCap <= '0;
    else if (start && !busy) modCap <= modIn;
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_below_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < modCap));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind scaled_mod_reducer modred_chk #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .modIn(modIn), .result(result)
);

// File: tb/sim_scaled_mod_reducer.sv
module sim_scaled_mod_reducer;
  localparam int N      = 4;
  localparam int W      = 16;
  localparam int VAL_W  = 2 * N * W;
  localparam int MOD_W  = N * W;
  localparam int SC_W   = (N + 1) * W;
  localparam int WIDE_W = SC_W + W;
  localparam int LIMIT  = 3000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              formSel = 1'b0;
  logic [VAL_W-1:0]  valueIn = '0;
  logic [MOD_W-1:0]  modIn = '0;
  logic [SC_W-1:0]   scaledIn = '0;
  logic [MOD_W-1:0]  result;
  logic              done;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  scaled_mod_reducer #(.N_DIGITS(N), .DIGIT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .formSel(formSel),
    .valueIn(valueIn), .modIn(modIn), .scaledIn(scaledIn),
    .result(result), .done(done)
  );

  always @(posedge clk) begin
    if (done) doneCnt <= doneCnt + 1;
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [VAL_W-1:0] act, input logic [VAL_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SC_W-1:0] scaleTopOnes(input logic [MOD_W-1:0] m);
    logic [WIDE_W-1:0] target, mm, s, prod;
    target = {{W{1'b0}}, {W{1'b1}}, {MOD_W{1'b0}}};
    mm     = WIDE_W'(m);
    s      = (target + mm - WIDE_W'(1)) / mm;
    prod   = s * mm;
    return prod[SC_W-1:0];
  endfunction

  function automatic bit scaleOneZero(input logic [MOD_W-1:0] m, output logic [SC_W-1:0] ms);
    logic [WIDE_W-1:0] target, limit, mm, s, prod;
    target = WIDE_W'(1) << MOD_W;
    limit  = target + (WIDE_W'(1) << (MOD_W - W));
    mm     = WIDE_W'(m);
    s      = (target + mm - WIDE_W'(1)) / mm;
    prod   = s * mm;
    ms     = prod[SC_W-1:0];
    return prod < limit;
  endfunction

  function automatic logic [VAL_W-1:0] randValue();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Runs one operation from an idle block and checks R4, R5 and the given tag.
  task automatic runOp(input logic [VAL_W-1:0] v, input logic [MOD_W-1:0] m,
                       input logic [SC_W-1:0] ms, input logic f, input string tag);
    logic [VAL_W-1:0] expv;
    int cnt;
    expv = v % VAL_W'(m);
    @(negedge clk);
    valueIn = v; modIn = m; scaledIn = ms; formSel = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < LIMIT) begin
      @(negedge clk);
      cnt++;
    end
    check(done, {tag, " done within limit"}, VAL_W'(done), VAL_W'(1));
    if (done) begin
      check(VAL_W'(result) == expv, tag, VAL_W'(result), expv);
      check(result < m, "R4 result below modulus", VAL_W'(result), VAL_W'(m));
    end
    @(negedge clk);
    check(!done, "R5 done lasts one cycle", VAL_W'(done), '0);
  endtask

  initial begin
    logic [MOD_W-1:0] m;
    logic [SC_W-1:0]  ms;
    logic [VAL_W-1:0] v;
    logic [VAL_W-1:0] held;
    int snap;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check(!done, "R1 done after reset", VAL_W'(done), '0);
    check(result == '0, "R1 result after reset", VAL_W'(result), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: random, pattern 0 (top bit of m set)
    for (int i = 0; i < 20; i++) begin
      m = {$urandom, $urandom};
      m[MOD_W-1] = 1'b1;
      runOp(randValue(), m, scaleTopOnes(m), 1'b0, "R2 pattern0 random");
    end

    // R3: random, pattern 1 (search for a valid S)
    for (int i = 0; i < 20; i++) begin
      bit ok = 1'b0;
      for (int t = 0; t < 64 && !ok; t++) begin
        m = {$urandom, $urandom};
        m[MOD_W-1 -: W] = W'(1 + ($urandom % 3));
        ok = scaleOneZero(m, ms);
      end
      if (ok) runOp(randValue(), m, ms, 1'b1, "R3 pattern1 random");
    end

    // R8: value below modulus, exact multiple, zero
    m = {$urandom, $urandom}; m[MOD_W-1] = 1'b1;
    runOp(VAL_W'(m) - VAL_W'(1), m, scaleTopOnes(m), 1'b0, "R8 below modulus unchanged");
    runOp(VAL_W'(m) * VAL_W'($urandom), m, scaleTopOnes(m), 1'b0, "R8 multiple gives zero");
    runOp('0, m, scaleTopOnes(m), 1'b0, "R8 zero value");
    m = 64'h0001_2345_6789_abcd;
    if (scaleOneZero(m, ms)) begin
      runOp(VAL_W'(m) * VAL_W'(32'h0000_ffff), m, ms, 1'b1, "R8 multiple pattern1");
      runOp(VAL_W'(m), m, ms, 1'b1, "R8 equal to modulus");
    end

    // R9: all-ones value with extreme moduli
    v = '1;
    m = '1;
    runOp(v, m, scaleTopOnes(m), 1'b0, "R9 max modulus");
    m = '0; m[MOD_W-1] = 1'b1;
    runOp(v, m, scaleTopOnes(m), 1'b0, "R9 min normalized modulus");
    m = 64'h0001_0000_0000_0001;
    if (scaleOneZero(m, ms)) runOp(v, m, ms, 1'b1, "R9 all-ones pattern1");

    // R7: result holds while idle
    held = VAL_W'(result);
    repeat (12) @(negedge clk);
    check(VAL_W'(result) == held, "R7 result held while idle", VAL_W'(result), held);

    // R6: start during a run is ignored
    m = {$urandom, $urandom}; m[MOD_W-1] = 1'b1;
    v = randValue();
    snap = doneCnt;
    @(negedge clk);
    valueIn = v; modIn = m; scaledIn = scaleTopOnes(m); formSel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    valueIn = randValue(); modIn = 64'h8000_0000_0000_0003;
    scaledIn = scaleTopOnes(64'h8000_0000_0000_0003); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < LIMIT && !done; c++) @(negedge clk);
    check(VAL_W'(result) == (v % VAL_W'(m)), "R6 first operands kept",
          VAL_W'(result), v % VAL_W'(m));
    repeat (200) @(negedge clk);
    check((doneCnt - snap) == 1, "R6 single done", VAL_W'(doneCnt - snap), VAL_W'(1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule